// File: doc/BRIEF.md
# DRAM Bank Row State and Timing Tracker

This block tracks, for every bank of a single DRAM rank, whether a row is open, which row it is, and how many cycles remain before each kind of command may be sent to that bank again. A scheduler presents one proposed command per cycle: activate, read, write or precharge, with a bank index and a row address. The tracker answers combinationally whether that command is legal in the current cycle. A legal command that is marked valid is accepted and updates the bank. An illegal command that is marked valid is flagged as an error and leaves all state untouched.

A separate query port classifies an address against the current bank state as closed, row hit or row miss. Each bank also counts the column accesses made to its open row. Once a configurable cap is reached, the bank raises a close request and refuses further column commands until it is precharged. All timing values are counted in controller clock cycles and fixed at elaboration.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset every bank is closed, an activate to any bank is legal, no close request is raised, and a query returns closed.
- R2: An activate is legal only to a closed bank. It opens the bank with the given row.
- R3: A read or write is legal only to an open bank, and no earlier than T_RCD cycles after that bank's activate.
- R4: A precharge is legal only to an open bank, and no earlier than T_RAS cycles after that bank's activate.
- R5: An activate is legal no earlier than T_RP cycles after that bank's precharge.
- R6: A precharge is legal no earlier than T_RTP cycles after the most recent read to that bank.
- R7: A precharge is legal no earlier than T_BURST + T_WR cycles after the most recent write to that bank. The write data is taken to end T_BURST cycles after the command.
- R8: The query status is 2'd0 when the bank is closed, 2'd1 when the open row equals the queried row, and 2'd2 when a different row is open.
- R9: After ACC_CAP accepted reads or writes to the open row, the bank's close request bit is set and further reads and writes to it are illegal. An accepted precharge clears the request.
- R10: A valid command that is illegal, or that has opcode 0 (none), sets error_o, keeps accept_o low and changes no bank state.
- R11: Commands to one bank affect neither the legality nor the row state of any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Proposed command is to be executed if legal |
| cmd_op_i | input | 3 | Opcode: 0 none, 1 activate, 2 read, 3 write, 4 precharge |
| cmd_bank_i | input | BANK_W | Target bank |
| cmd_row_i | input | ROW_W | Row address for an activate |
| legal_o | output | 1 | Proposed command is legal this cycle |
| accept_o | output | 1 | Command valid and legal; state updates at the clock edge |
| error_o | output | 1 | Command valid but illegal; ignored |
| query_bank_i | input | BANK_W | Bank to classify |
| query_row_i | input | ROW_W | Row to classify |
| query_stat_o | output | 2 | 0 closed, 1 hit, 2 miss |
| close_req_o | output | NUM_BANKS | Per-bank request to precharge after the access cap |

## Verification
The bench probes legality in every cycle of each timing window. A counter that is off by one shows up as a command allowed one cycle early or refused one cycle late at the window edge. It issues a read late in the activate-to-precharge window to check that the read-to-precharge rule extends the window, rather than overwriting or ignoring it. A write checks that the longer write recovery is also applied. Two further cases target state handling. The access-cap case checks for a request that fires one access early, leaves column commands open, or survives the precharge. The illegal activate to an open bank would, in a faulty design, silently replace the open row, and the hit/miss query would then expose it.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_CLOSED = 2'd0,
    ST_HIT    = 2'd1,
    ST_MISS   = 2'd2
  } stat_e;
endpackage

// File: rtl/dbt_bank.sv
module dbt_bank #(
  parameter int ROW_W   = 14,
  parameter int T_RCD   = 4,
  parameter int T_RAS   = 10,
  parameter int T_RP    = 4,
  parameter int T_RTP   = 3,
  parameter int T_WR    = 5,
  parameter int T_BURST = 4,
  parameter int ACC_CAP = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_ok_o,
  output logic             col_ok_o,
  output logic             pre_ok_o,
  output logic             close_req_o
);
  localparam int T_WPRE = T_BURST + T_WR;
  localparam int M1 = (T_RCD > T_RAS) ? T_RCD : T_RAS;
  localparam int M2 = (T_RP > T_RTP) ? T_RP : T_RTP;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int CNT_MAX = (M3 > T_WPRE) ? M3 : T_WPRE;
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int ACC_W = $clog2(ACC_CAP + 1);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] act_cnt_q, col_cnt_q, pre_cnt_q;
  logic [CNT_W-1:0] pre_dec;
  logic [ACC_W-1:0] acc_q;

  assign pre_dec     = (pre_cnt_q == '0) ? '0 : pre_cnt_q - 1'b1;
  assign close_req_o = open_q && (acc_q == ACC_W'(ACC_CAP));
  assign act_ok_o    = !open_q && (act_cnt_q == '0);
  assign col_ok_o    = open_q && (col_cnt_q == '0) && !close_req_o;
  assign pre_ok_o    = open_q && (pre_cnt_q == '0);
  assign open_o      = open_q;
  assign row_o       = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      row_q     <= '0;
      act_cnt_q <= '0;
      col_cnt_q <= '0;
      pre_cnt_q <= '0;
      acc_q     <= '0;
    end else begin
      act_cnt_q <= (act_cnt_q == '0) ? '0 : act_cnt_q - 1'b1;
      col_cnt_q <= (col_cnt_q == '0) ? '0 : col_cnt_q - 1'b1;
      pre_cnt_q <= pre_dec;
      if (act_i) begin
        open_q    <= 1'b1;
        row_q     <= row_i;
        col_cnt_q <= CNT_W'(T_RCD - 1);
        pre_cnt_q <= CNT_W'(T_RAS - 1);
        acc_q     <= '0;
      end else if (pre_i) begin
        open_q    <= 1'b0;
        act_cnt_q <= CNT_W'(T_RP - 1);
        acc_q     <= '0;
      end else if (rd_i || wr_i) begin
        acc_q <= acc_q + 1'b1;
        // keep the later of the running bound and the new recovery bound
        if (rd_i && pre_dec < CNT_W'(T_RTP - 1))      pre_cnt_q <= CNT_W'(T_RTP - 1);
        else if (wr_i && pre_dec < CNT_W'(T_WPRE - 1)) pre_cnt_q <= CNT_W'(T_WPRE - 1);
      end
    end
  end

  a_r2_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_q && row_q == $past(row_i));
  a_r9_pre_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |=> !open_q && !close_req_o);
  a_r7_wr_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !pre_ok_o);

  if (T_RCD > 1) begin : g_rcd
    a_r3_rcd_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i |=> !col_ok_o);
  end
  if (T_RAS > 1) begin : g_ras
    a_r4_ras_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i |=> !pre_ok_o);
  end
  if (T_RP > 1) begin : g_rp
    a_r5_rp_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pre_i |=> !act_ok_o);
  end
  if (T_RTP > 1) begin : g_rtp
    a_r6_rtp_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_i |=> !pre_ok_o);
  end
endmodule

// File: rtl/dbt_issue.sv
module dbt_issue
  import dbt_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [2:0]           op_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [NUM_BANKS-1:0] act_ok_i,
  input  logic [NUM_BANKS-1:0] col_ok_i,
  input  logic [NUM_BANKS-1:0] pre_ok_i,
  output logic [NUM_BANKS-1:0] act_fire_o,
  output logic [NUM_BANKS-1:0] rd_fire_o,
  output logic [NUM_BANKS-1:0] wr_fire_o,
  output logic [NUM_BANKS-1:0] pre_fire_o,
  output logic                 legal_o,
  output logic                 accept_o,
  output logic                 error_o
);
  op_e  op;
  logic in_range;

  assign op       = op_e'(op_i);
  assign in_range = int'(bank_i) < NUM_BANKS;

  always_comb begin
    legal_o = 1'b0;
    if (in_range) begin
      unique case (op)
        OP_ACT:        legal_o = act_ok_i[bank_i];
        OP_RD, OP_WR:  legal_o = col_ok_i[bank_i];
        OP_PRE:        legal_o = pre_ok_i[bank_i];
        default:       legal_o = 1'b0;
      endcase
    end
  end

  assign accept_o = valid_i && legal_o;
  assign error_o  = valid_i && !legal_o;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_fire
    logic sel;
    assign sel           = accept_o && (int'(bank_i) == b);
    assign act_fire_o[b] = sel && (op == OP_ACT);
    assign rd_fire_o[b]  = sel && (op == OP_RD);
    assign wr_fire_o[b]  = sel && (op == OP_WR);
    assign pre_fire_o[b] = sel && (op == OP_PRE);
  end

  a_r11_one_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_fire_o | rd_fire_o | wr_fire_o | pre_fire_o));
endmodule

// File: rtl/dbt_query.sv
module dbt_query
  import dbt_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 14
) (
  input  logic [NUM_BANKS-1:0]            open_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] row_i,
  input  logic [BANK_W-1:0]               bank_i,
  input  logic [ROW_W-1:0]                qrow_i,
  output logic [1:0]                      stat_o
);
  stat_e st;
  always_comb begin
    st = ST_CLOSED;
    if (int'(bank_i) < NUM_BANKS && open_i[bank_i])
      st = (row_i[bank_i] == qrow_i) ? ST_HIT : ST_MISS;
  end
  assign stat_o = st;
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int T_RCD     = 4,
  parameter int T_RAS     = 10,
  parameter int T_RP      = 4,
  parameter int T_RTP     = 3,
  parameter int T_WR      = 5,
  parameter int T_BURST   = 4,
  parameter int ACC_CAP   = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_op_i,
  input  logic [BANK_W-1:0]    cmd_bank_i,
  input  logic [ROW_W-1:0]     cmd_row_i,
  output logic                 legal_o,
  output logic                 accept_o,
  output logic                 error_o,
  input  logic [BANK_W-1:0]    query_bank_i,
  input  logic [ROW_W-1:0]     query_row_i,
  output logic [1:0]           query_stat_o,
  output logic [NUM_BANKS-1:0] close_req_o
);
  logic [NUM_BANKS-1:0] act_ok, col_ok, pre_ok, open_vec;
  logic [NUM_BANKS-1:0] act_fire, rd_fire, wr_fire, pre_fire;
  logic [NUM_BANKS-1:0][ROW_W-1:0] row_arr;

  dbt_issue #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_issue (
    .clk_i, .rst_ni,
    .valid_i(cmd_valid_i), .op_i(cmd_op_i), .bank_i(cmd_bank_i),
    .act_ok_i(act_ok), .col_ok_i(col_ok), .pre_ok_i(pre_ok),
    .act_fire_o(act_fire), .rd_fire_o(rd_fire), .wr_fire_o(wr_fire), .pre_fire_o(pre_fire),
    .legal_o, .accept_o, .error_o
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dbt_bank #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
      .T_RTP(T_RTP), .T_WR(T_WR), .T_BURST(T_BURST), .ACC_CAP(ACC_CAP)
    ) u_bank (
      .clk_i, .rst_ni,
      .act_i(act_fire[b]), .rd_i(rd_fire[b]), .wr_i(wr_fire[b]), .pre_i(pre_fire[b]),
      .row_i(cmd_row_i),
      .open_o(open_vec[b]), .row_o(row_arr[b]),
      .act_ok_o(act_ok[b]), .col_ok_o(col_ok[b]), .pre_ok_o(pre_ok[b]),
      .close_req_o(close_req_o[b])
    );
  end

  dbt_query #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_query (
    .open_i(open_vec), .row_i(row_arr), .bank_i(query_bank_i),
    .qrow_i(query_row_i), .stat_o(query_stat_o)
  );

  a_r10_error_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> $stable(open_vec) && $stable(row_arr));
  a_r10_accept_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && error_o));
endmodule

// File: tb/dram_bank_tracker_tb.sv
module dram_bank_tracker_tb;
  localparam int NB = 8;
  localparam int RW = 14;
  localparam logic [2:0] NONE = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [2:0] op = NONE;
  logic [2:0] bank = '0;
  logic [RW-1:0] row = '0;
  logic [2:0] qbank = '0;
  logic [RW-1:0] qrow = '0;
  logic legal, accept, err;
  logic [1:0] qstat;
  logic [NB-1:0] creq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dram_bank_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_op_i(op),
    .cmd_bank_i(bank), .cmd_row_i(row), .legal_o(legal), .accept_o(accept),
    .error_o(err), .query_bank_i(qbank), .query_row_i(qrow),
    .query_stat_o(qstat), .close_req_o(creq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, settle, caller samples before the next edge
  task automatic drive(input logic v, input logic [2:0] o, input int b, input int r);
    @(negedge clk);
    valid = v; op = o; bank = 3'(b); row = RW'(r);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, NONE, 0, 0);
  endtask

  task automatic query(input int b, input int r, input int exp, input string tag);
    qbank = 3'(b); qrow = RW'(r); #1;
    chk(tag, qstat, exp);
  endtask

  task automatic t_reset;
    for (int b = 0; b < NB; b++) begin
      drive(1'b0, ACT, b, 0);
      chk("R1 act legal after reset", legal, 1);
      query(b, 0, 0, "R1 closed after reset");
    end
    chk("R1 no close request", int'(creq), 0);
  endtask

  task automatic t_act_col;
    drive(1'b1, ACT, 1, 5);
    chk("R2 act accepted", accept, 1);
    for (int c = 1; c < 4; c++) begin
      drive(1'b0, RD, 1, 0);
      chk("R3 read before tRCD", legal, 0);
    end
    drive(1'b1, RD, 1, 0);
    chk("R3 read at tRCD", accept, 1);
    drive(1'b1, ACT, 1, 7);
    chk("R2 act to open bank illegal", legal, 0);
    chk("R10 error flagged", err, 1);
    chk("R10 not accepted", accept, 0);
    drive(1'b1, NONE, 1, 0);
    chk("R10 none opcode error", err, 1);
    drive(1'b0, NONE, 0, 0);
    query(1, 5, 1, "R8 hit / R10 row kept");
    query(1, 7, 2, "R8 miss");
    drive(1'b0, ACT, 6, 0);
    chk("R11 other bank act legal", legal, 1);
    query(6, 5, 0, "R11 other bank closed");
    drive(1'b0, RD, 6, 0);
    chk("R3 read to closed bank", legal, 0);
  endtask

  task automatic t_ras_rp;
    drive(1'b1, ACT, 2, 9);
    for (int c = 1; c < 10; c++) begin
      drive(1'b0, PRE, 2, 0);
      chk("R4 precharge before tRAS", legal, 0);
    end
    drive(1'b1, PRE, 2, 0);
    chk("R4 precharge at tRAS", accept, 1);
    for (int c = 1; c < 4; c++) begin
      drive(1'b0, ACT, 2, 0);
      chk("R5 act before tRP", legal, 0);
    end
    query(2, 9, 0, "R8 closed after precharge");
    drive(1'b1, ACT, 2, 3);
    chk("R5 act at tRP", accept, 1);
    drive(1'b0, PRE, 2, 0);
    chk("R4 precharge right after act", legal, 0);
  endtask

  task automatic t_rtp;
    drive(1'b1, ACT, 3, 1);
    idle(7);
    drive(1'b1, RD, 3, 0);
    chk("R6 late read accepted", accept, 1);
    for (int c = 9; c < 11; c++) begin
      drive(1'b0, PRE, 3, 0);
      chk("R6 precharge before tRTP", legal, 0);
    end
    drive(1'b1, PRE, 3, 0);
    chk("R6 precharge at tRTP", accept, 1);
  endtask

  task automatic t_wr;
    drive(1'b1, ACT, 4, 2);
    idle(3);
    drive(1'b1, WR, 4, 0);
    chk("R7 write accepted", accept, 1);
    for (int c = 5; c < 13; c++) begin
      drive(1'b0, PRE, 4, 0);
      chk("R7 precharge before write recovery", legal, 0);
    end
    drive(1'b1, PRE, 4, 0);
    chk("R7 precharge at write recovery", accept, 1);
  endtask

  task automatic t_cap;
    drive(1'b1, ACT, 5, 11);
    idle(3);
    for (int n = 0; n < 16; n++) begin
      drive(1'b1, RD, 5, 0);
      chk("R9 access under cap", accept, 1);
      if (n < 15) chk("R9 no early request", int'(creq[5]), 0);
    end
    drive(1'b0, RD, 5, 0);
    chk("R9 request at cap", int'(creq[5]), 1);
    chk("R9 column blocked at cap", legal, 0);
    chk("R11 request only on bank 5", int'(creq), 32);
    drive(1'b0, PRE, 5, 0);
    chk("R9 precharge waits tRTP", legal, 0);
    drive(1'b1, PRE, 5, 0);
    chk("R9 precharge accepted", accept, 1);
    drive(1'b0, NONE, 0, 0);
    chk("R9 request cleared", int'(creq[5]), 0);
    query(5, 11, 0, "R9 bank closed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_act_col();
    t_ras_rp();
    t_rtp();
    t_wr();
    t_cap();
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule